// File: doc/BRIEF.md
# Lockable Sector Cache Tag Directory

This block holds the tag state of a small, fully associative instruction cache with eight sectors. Every sector keeps the tag of the memory sector mapped into it, a valid flag, a lock flag and a recency rank. Ranks form a true least-recently-used order: rank 0 is the most recent sector and rank 7 is the oldest. A normal lookup reports hit or miss in the same cycle. On the following clock edge it moves the hit sector to the front. On a miss it fills the oldest unlocked sector instead.

A second lookup path, the probe, is meant for a debugger. It reports hit and sector index exactly like a normal lookup but never changes tags, locks or ranks. A debug write path loads the tag and lock flag of any chosen sector. A readout path walks a pointer across the sectors. It presents each entry's valid flag, lock flag, rank and tag on one word, so software can dump the whole directory one entry after another.

Top module: `sector_tag_dir`

## Requirements
- R1: After reset every sector is invalid and unlocked, its tag is zero, and sector i holds rank i.
- R2: A normal lookup raises `lkHit` in the same cycle, with `lkHitIdx` naming the sector, when a valid sector holds `lkTag`. An invalid sector never hits.
- R3: On the edge after a normal lookup hit, the hit sector takes rank 0. Sectors whose rank was below its old rank move up by one, and all other ranks stay as they were.
- R4: On a normal miss, `lkVictimIdx` names the unlocked sector with the highest rank. On the next edge that sector takes `lkTag`, becomes valid and takes rank 0, and the ranks of the other sectors change as in R3.
- R5: A normal miss while every sector is locked raises `lkNoVictim` in the same cycle and changes no tag, flag or rank. A hit on a locked sector still updates ranks as in R3.
- R6: The probe reports `prbHit` and `prbHitIdx` in the same cycle under the match rule of R2. It never changes any tag, flag or rank, whether it hits or misses, and also when a normal lookup runs in the same cycle.
- R7: A debug write loads `dbgWrTag` and `dbgWrLock` into sector `dbgWrIdx` and sets its valid flag. Ranks do not change.
- R8: When a debug write and a normal lookup fall in the same cycle, the lookup still reports its outputs, but only the debug write changes the state.
- R9: `dbgRdRestart` returns the readout pointer to 0. Otherwise `dbgRdStep` advances it, wrapping from 7 to 0, and restart wins over step. `dbgRdWord` shows the entry at the pointer as {valid (MSB), lock, rank (3 bits), tag (low TAG_W bits)}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Normal lookup request |
| lkTag | input | TAG_W | Tag of the normal lookup |
| lkHit | output | 1 | Normal lookup hit |
| lkHitIdx | output | 3 | Sector that hit |
| lkVictimIdx | output | 3 | Sector that a miss would fill |
| lkNoVictim | output | 1 | Miss with every sector locked |
| prbValid | input | 1 | Debug probe request |
| prbTag | input | TAG_W | Tag of the debug probe |
| prbHit | output | 1 | Probe hit |
| prbHitIdx | output | 3 | Sector that the probe hit |
| dbgWrEn | input | 1 | Debug write strobe |
| dbgWrIdx | input | 3 | Sector to write |
| dbgWrTag | input | TAG_W | Tag to load |
| dbgWrLock | input | 1 | Lock flag to load |
| dbgRdRestart | input | 1 | Return readout pointer to 0 |
| dbgRdStep | input | 1 | Advance readout pointer |
| dbgRdPtr | output | 3 | Current readout pointer |
| dbgRdWord | output | TAG_W+5 | Entry at the readout pointer |

## Verification
The probe and a normal lookup can fall in the same cycle. So can a debug write and a normal lookup. The bench drives both pairs together, with equal tags and with different tags, and with hits and misses on each side. After every such cycle, a behavioural model and a readout word compared on every clock judge the result: only the normal lookup may move ranks or fill a sector, and in a cycle that also carries a debug write only the write may change state. The checker adds that probe-only and write cycles leave the ranks unchanged, and that equal-tag probe and lookup give the same answer.

// File: rtl/sector_tag_pkg.sv
package sector_tag_pkg;
  typedef struct packed {
    logic touchEn;   // move the hit sector to the front
    logic fillEn;    // load the victim with the lookup tag
    logic wrEn;      // apply the debug write
    logic rdRestart; // readout pointer back to 0
    logic rdStep;    // readout pointer forward
  } ctrlStrobes_t;
endpackage

// File: rtl/sector_tag_ctrl.sv
module sector_tag_ctrl
  import sector_tag_pkg::*;
(
  input  logic         lkValid,
  input  logic         lkMatch,
  input  logic         victimFound,
  input  logic         dbgWrEn,
  input  logic         dbgRdRestart,
  input  logic         dbgRdStep,
  output logic         noVictim,
  output ctrlStrobes_t strobes
);
  logic lookupMayUpdate;

  // A debug write in the same cycle holds back any lookup update.
  assign lookupMayUpdate = lkValid && !dbgWrEn;

  always_comb begin
    strobes.touchEn   = lookupMayUpdate && lkMatch;
    strobes.fillEn    = lookupMayUpdate && !lkMatch && victimFound;
    strobes.wrEn      = dbgWrEn;
    strobes.rdRestart = dbgRdRestart;
    strobes.rdStep    = dbgRdStep && !dbgRdRestart;
  end

  assign noVictim = lkValid && !lkMatch && !victimFound;
endmodule

// File: rtl/sector_tag_dp.sv
module sector_tag_dp
  import sector_tag_pkg::*;
#(
  parameter int TAG_W    = 12,
  parameter int NUM_SECT = 8,
  localparam int IDX_W   = $clog2(NUM_SECT),
  localparam int WORD_W  = TAG_W + IDX_W + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [TAG_W-1:0]           lkTag,
  input  logic [TAG_W-1:0]           prbTag,
  input  logic                       prbValid,
  input  logic [IDX_W-1:0]           dbgWrIdx,
  input  logic [TAG_W-1:0]           dbgWrTag,
  input  logic                       dbgWrLock,
  output logic                       lkMatch,
  output logic [IDX_W-1:0]           lkMatchIdx,
  output logic                       prbMatch,
  output logic [IDX_W-1:0]           prbMatchIdx,
  output logic                       victimFound,
  output logic [IDX_W-1:0]           victimIdx,
  output logic [IDX_W-1:0]           rdPtr,
  output logic [WORD_W-1:0]          rdWord,
  output logic [NUM_SECT*WORD_W-1:0] stateFlat
);
  logic [TAG_W-1:0] tagA  [NUM_SECT];
  logic [IDX_W-1:0] rankA [NUM_SECT];
  logic             valA  [NUM_SECT];
  logic             lockA [NUM_SECT];

  logic [IDX_W-1:0] mruIdx;
  logic [IDX_W-1:0] mruOldRank;
  logic             mruEn;

  // The sector that becomes most recent, and the rank it leaves behind.
  assign mruEn      = strobes.touchEn || strobes.fillEn;
  assign mruIdx     = strobes.touchEn ? lkMatchIdx : victimIdx;
  assign mruOldRank = rankA[mruIdx];

  for (genvar gi = 0; gi < NUM_SECT; gi++) begin : g_sect
    logic [TAG_W-1:0] tagR;
    logic [IDX_W-1:0] rankR;
    logic             valR;
    logic             lockR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagR  <= '0;
        valR  <= 1'b0;
        lockR <= 1'b0;
        rankR <= IDX_W'(gi);
      end else begin
        if (strobes.wrEn && dbgWrIdx == IDX_W'(gi)) begin
          tagR  <= dbgWrTag;
          valR  <= 1'b1;
          lockR <= dbgWrLock;
        end else if (strobes.fillEn && victimIdx == IDX_W'(gi)) begin
          tagR <= lkTag;
          valR <= 1'b1;
        end
        if (mruEn) begin
          if (mruIdx == IDX_W'(gi))   rankR <= '0;
          else if (rankR < mruOldRank) rankR <= rankR + 1'b1;
        end
      end
    end

    assign tagA[gi]  = tagR;
    assign rankA[gi] = rankR;
    assign valA[gi]  = valR;
    assign lockA[gi] = lockR;
    assign stateFlat[gi*WORD_W +: WORD_W] = {valR, lockR, rankR, tagR};
  end

  // Associative match for the normal lookup and for the probe.
  always_comb begin
    lkMatch     = 1'b0;
    lkMatchIdx  = '0;
    prbMatch    = 1'b0;
    prbMatchIdx = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (valA[i] && tagA[i] == lkTag && !lkMatch) begin
        lkMatch    = 1'b1;
        lkMatchIdx = IDX_W'(i);
      end
      if (prbValid && valA[i] && tagA[i] == prbTag && !prbMatch) begin
        prbMatch    = 1'b1;
        prbMatchIdx = IDX_W'(i);
      end
    end
  end

  // Oldest unlocked sector.
  always_comb begin
    logic [IDX_W-1:0] bestRank;
    victimFound = 1'b0;
    victimIdx   = '0;
    bestRank    = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (!lockA[i] && (!victimFound || rankA[i] > bestRank)) begin
        victimFound = 1'b1;
        victimIdx   = IDX_W'(i);
        bestRank    = rankA[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  rdPtr <= '0;
    else if (strobes.rdRestart) rdPtr <= '0;
    else if (strobes.rdStep)
      rdPtr <= (rdPtr == IDX_W'(NUM_SECT - 1)) ? '0 : rdPtr + 1'b1;
  end

  assign rdWord = {valA[rdPtr], lockA[rdPtr], rankA[rdPtr], tagA[rdPtr]};
endmodule

// File: rtl/sector_tag_dir.sv
module sector_tag_dir
  import sector_tag_pkg::*;
#(
  parameter int TAG_W    = 12,
  parameter int NUM_SECT = 8,
  localparam int IDX_W   = $clog2(NUM_SECT),
  localparam int WORD_W  = TAG_W + IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [TAG_W-1:0]  lkTag,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkHitIdx,
  output logic [IDX_W-1:0]  lkVictimIdx,
  output logic              lkNoVictim,
  input  logic              prbValid,
  input  logic [TAG_W-1:0]  prbTag,
  output logic              prbHit,
  output logic [IDX_W-1:0]  prbHitIdx,
  input  logic              dbgWrEn,
  input  logic [IDX_W-1:0]  dbgWrIdx,
  input  logic [TAG_W-1:0]  dbgWrTag,
  input  logic              dbgWrLock,
  input  logic              dbgRdRestart,
  input  logic              dbgRdStep,
  output logic [IDX_W-1:0]  dbgRdPtr,
  output logic [WORD_W-1:0] dbgRdWord
);
  ctrlStrobes_t              strobes;
  logic                      lkMatch;
  logic                      victimFound;
  logic [NUM_SECT*WORD_W-1:0] stateFlat;

  sector_tag_ctrl ctrl_i (
    .lkValid     (lkValid),
    .lkMatch     (lkMatch),
    .victimFound (victimFound),
    .dbgWrEn     (dbgWrEn),
    .dbgRdRestart(dbgRdRestart),
    .dbgRdStep   (dbgRdStep),
    .noVictim    (lkNoVictim),
    .strobes     (strobes)
  );

  sector_tag_dp #(.TAG_W(TAG_W), .NUM_SECT(NUM_SECT)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .lkTag      (lkTag),
    .prbTag     (prbTag),
    .prbValid   (prbValid),
    .dbgWrIdx   (dbgWrIdx),
    .dbgWrTag   (dbgWrTag),
    .dbgWrLock  (dbgWrLock),
    .lkMatch    (lkMatch),
    .lkMatchIdx (lkHitIdx),
    .prbMatch   (prbHit),
    .prbMatchIdx(prbHitIdx),
    .victimFound(victimFound),
    .victimIdx  (lkVictimIdx),
    .rdPtr      (dbgRdPtr),
    .rdWord     (dbgRdWord),
    .stateFlat  (stateFlat)
  );

  assign lkHit = lkValid && lkMatch;
endmodule

// File: rtl/sector_tag_dir_chk.sv
module sector_tag_dir_chk #(
  parameter int TAG_W    = 12,
  parameter int NUM_SECT = 8,
  localparam int IDX_W   = $clog2(NUM_SECT),
  localparam int WORD_W  = TAG_W + IDX_W + 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       lkValid,
  input logic [TAG_W-1:0]           lkTag,
  input logic                       lkHit,
  input logic [IDX_W-1:0]           lkHitIdx,
  input logic                       lkNoVictim,
  input logic                       prbValid,
  input logic [TAG_W-1:0]           prbTag,
  input logic                       prbHit,
  input logic                       dbgWrEn,
  input logic [NUM_SECT*WORD_W-1:0] stateFlat
);
  logic [NUM_SECT*IDX_W-1:0] rankVec;
  logic                      permOk;

  always_comb begin
    for (int i = 0; i < NUM_SECT; i++)
      rankVec[i*IDX_W +: IDX_W] = stateFlat[i*WORD_W + TAG_W +: IDX_W];
  end

  always_comb begin
    permOk = 1'b1;
    for (int v = 0; v < NUM_SECT; v++) begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < NUM_SECT; i++)
        if (rankVec[i*IDX_W +: IDX_W] == IDX_W'(v)) cnt++;
      if (cnt != 1) permOk = 1'b0;
    end
  end

  p_rank_perm_r3: assert property (@(posedge clk) disable iff (!rstN) permOk);

  p_hit_front_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && !dbgWrEn) |=> (rankVec[$past(lkHitIdx)*IDX_W +: IDX_W] == '0));

  p_novictim_miss_r5: assert property (@(posedge clk) disable iff (!rstN)
    lkNoVictim |-> (lkValid && !lkHit));

  p_novictim_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lkNoVictim && !dbgWrEn) |=> $stable(stateFlat));

  p_probe_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!lkValid && !dbgWrEn) |=> $stable(stateFlat));

  p_probe_agree_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && prbValid && lkTag == prbTag) |-> (prbHit == lkHit));

  p_write_keeps_rank_r8: assert property (@(posedge clk) disable iff (!rstN)
    dbgWrEn |=> $stable(rankVec));
endmodule

bind sector_tag_dir sector_tag_dir_chk #(.TAG_W(TAG_W), .NUM_SECT(NUM_SECT)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .lkValid   (lkValid),
  .lkTag     (lkTag),
  .lkHit     (lkHit),
  .lkHitIdx  (lkHitIdx),
  .lkNoVictim(lkNoVictim),
  .prbValid  (prbValid),
  .prbTag    (prbTag),
  .prbHit    (prbHit),
  .dbgWrEn   (dbgWrEn),
  .stateFlat (stateFlat)
);

// File: tb/sector_tag_dir_tb_top.sv
module sector_tag_dir_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W      = 12;
  localparam int NS         = 8;
  localparam int WORD_W     = TAG_W + 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lkValid = 1'b0;
  logic [TAG_W-1:0]  lkTag = '0;
  logic              lkHit;
  logic [2:0]        lkHitIdx;
  logic [2:0]        lkVictimIdx;
  logic              lkNoVictim;
  logic              prbValid = 1'b0;
  logic [TAG_W-1:0]  prbTag = '0;
  logic              prbHit;
  logic [2:0]        prbHitIdx;
  logic              dbgWrEn = 1'b0;
  logic [2:0]        dbgWrIdx = '0;
  logic [TAG_W-1:0]  dbgWrTag = '0;
  logic              dbgWrLock = 1'b0;
  logic              dbgRdRestart = 1'b0;
  logic              dbgRdStep = 1'b0;
  logic [2:0]        dbgRdPtr;
  logic [WORD_W-1:0] dbgRdWord;

  int checks = 0;
  int failures = 0;

  // Behavioural model
  int mTag[NS];
  int mVal[NS];
  int mLock[NS];
  int mRank[NS];
  int mPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_tag_dir #(.TAG_W(TAG_W), .NUM_SECT(NS)) dut_i (.*);

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int findTag(int t);
    for (int i = 0; i < NS; i++)
      if (mVal[i] != 0 && mTag[i] == t) return i;
    return -1;
  endfunction

  function automatic int findVictim();
    int v = -1;
    for (int i = 0; i < NS; i++)
      if (mLock[i] == 0 && (v < 0 || mRank[i] > mRank[v])) v = i;
    return v;
  endfunction

  task automatic makeRecent(int s);
    int old = mRank[s];
    for (int j = 0; j < NS; j++)
      if (j != s && mRank[j] < old) mRank[j]++;
    mRank[s] = 0;
  endtask

  task automatic modelReset();
    for (int i = 0; i < NS; i++) begin
      mTag[i] = 0; mVal[i] = 0; mLock[i] = 0; mRank[i] = i;
    end
    mPtr = 0;
  endtask

  // One clock: compare outputs, advance model, then return inputs to idle.
  task automatic tick(string req);
    int h, v, p;
    longint expWord;
    #1;
    h = findTag(int'(lkTag));
    v = findVictim();
    p = findTag(int'(prbTag));
    if (lkValid) begin
      check({req, " R2 lkHit"}, lkHit, h >= 0);
      if (h >= 0) check({req, " R2 lkHitIdx"}, lkHitIdx, h);
      check({req, " R5 lkNoVictim"}, lkNoVictim, (h < 0 && v < 0));
      if (h < 0 && v >= 0) check({req, " R4 lkVictimIdx"}, lkVictimIdx, v);
    end else begin
      check({req, " R2 idle lkHit"}, lkHit, 0);
    end
    if (prbValid) begin
      check({req, " R6 prbHit"}, prbHit, p >= 0);
      if (p >= 0) check({req, " R6 prbHitIdx"}, prbHitIdx, p);
    end
    check({req, " R9 ptr"}, dbgRdPtr, mPtr);
    expWord = (longint'(mVal[mPtr]) << (TAG_W + 4)) | (longint'(mLock[mPtr]) << (TAG_W + 3)) |
              (longint'(mRank[mPtr]) << TAG_W) | longint'(mTag[mPtr]);
    check({req, " word"}, dbgRdWord, expWord);
    @(posedge clk);
    if (dbgWrEn) begin
      mTag[dbgWrIdx] = int'(dbgWrTag); mVal[dbgWrIdx] = 1; mLock[dbgWrIdx] = int'(dbgWrLock);
    end else if (lkValid) begin
      if (h >= 0) makeRecent(h);
      else if (v >= 0) begin
        mTag[v] = int'(lkTag); mVal[v] = 1; makeRecent(v);
      end
    end
    if (dbgRdRestart) mPtr = 0;
    else if (dbgRdStep) mPtr = (mPtr + 1) % NS;
    @(negedge clk);
    lkValid = 0; prbValid = 0; dbgWrEn = 0; dbgRdRestart = 0; dbgRdStep = 0;
  endtask

  task automatic lookup(string req, int t);
    lkValid = 1; lkTag = TAG_W'(t); tick(req);
  endtask

  task automatic dbgWrite(string req, int idx, int t, int lock);
    dbgWrEn = 1; dbgWrIdx = 3'(idx); dbgWrTag = TAG_W'(t); dbgWrLock = 1'(lock); tick(req);
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < NS; k++) begin
      dbgRdStep = 1; tick(req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: reset contents seen through a full readout sweep (also R9 wrap)
    sweep("R1 reset");
    check("R9 wrap to 0", dbgRdPtr, 0);
    prbValid = 1; prbTag = '0; tick("R2 invalid never hits");

    // R4: fill all sectors by misses
    for (int k = 0; k < NS; k++) lookup("R4 fill", 'h100 + k);
    sweep("R4 after fill");

    // R2/R3: hits reorder ranks
    lookup("R3 hit", 'h103);
    lookup("R3 hit", 'h100);
    lookup("R3 hit", 'h107);
    lookup("R3 rehit", 'h107);
    sweep("R3 ranks");
    lookup("R4 evict", 'h200);
    lookup("R4 evict", 'h201);
    sweep("R4 ranks");

    // R6: probe alone and with a lookup in the same cycle
    prbValid = 1; prbTag = 'h105; tick("R6 probe hit");
    prbValid = 1; prbTag = 'h300; tick("R6 probe miss");
    prbValid = 1; prbTag = 'h103; lkValid = 1; lkTag = 'h103; tick("R6 probe+lookup same");
    prbValid = 1; prbTag = 'h301; lkValid = 1; lkTag = 'h302; tick("R6 probe+lookup miss");
    prbValid = 1; prbTag = 'h302; lkValid = 1; lkTag = 'h200; tick("R6 probe new tag");
    sweep("R6 state");

    // R7: debug writes
    dbgWrite("R7 write", 2, 'h0AA, 1);
    lookup("R7 locked hit", 'h0AA);
    sweep("R7 state");

    // R8: debug write together with a lookup
    dbgWrEn = 1; dbgWrIdx = 4; dbgWrTag = 'h0BB; dbgWrLock = 0;
    lkValid = 1; lkTag = 'h103; tick("R8 write+hit");
    dbgWrEn = 1; dbgWrIdx = 5; dbgWrTag = 'h0CC; dbgWrLock = 0;
    lkValid = 1; lkTag = 'h3FF; tick("R8 write+miss");
    sweep("R8 state");

    // R5: everything locked
    for (int k = 0; k < NS; k++) dbgWrite("R5 lock", k, 'h400 + k, 1);
    lookup("R5 no victim", 'h999);
    lookup("R5 no victim again", 'h998);
    lookup("R5 locked hit", 'h403);
    sweep("R5 state");
    dbgWrite("R4 unlock", 6, 'h406, 0);
    lookup("R4 only victim", 'h555);
    sweep("R4 state");

    // R9: pointer control
    dbgRdStep = 1; tick("R9 step");
    dbgRdStep = 1; tick("R9 step");
    dbgRdRestart = 1; tick("R9 restart");
    dbgRdStep = 1; tick("R9 step");
    dbgRdRestart = 1; dbgRdStep = 1; tick("R9 restart wins");
    tick("R9 hold");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule